// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the write cycles that a host issues to a byte-wide parallel NOR flash and recognises the multi-write unlock and command sequences hidden in them. Each write arrives as an address, a data word and a one-cycle strobe that has already been qualified from the bus edges. A recognised sequence produces a one-cycle command pulse on the cycle after its last write. The pulse carries a command code, an address and a data word. Recognised commands are word program, chip erase, sector erase, buffered program (one pulse per loaded word and one on confirm), suspend, resume, reset, query entry, identifier entry and secured-region entry.

The decoder also reports the mode the flash interface is in. The modes are read-array, identifier (autoselect), query, unlock-bypass, buffer-load and buffer-abort. An external busy input says when an embedded operation is running. While it is high, the decoder holds its sequence position, and a suspend request is the only write it accepts. The array, the operation timing and the status bits live elsewhere.

Top module: `nfcd_decoder`

## Requirements
- R1: A command sequence opens with data 0xAA at address 0xAAA and then data 0x55 at address 0x555. If either write does not match, the decoder goes back to idle, issues no command and does not interpret the mismatching write in any other way.
- R2: A write of 0xA0 to 0xAAA after the unlock pair arms a program. The next write issues cmd_kind 1 (program) with that write's address and data. cmd_valid is high for exactly the cycle after the final write.
- R3: A write of 0x80 to 0xAAA, then a second unlock pair, then 0x10 at 0xAAA issues cmd_kind 2 (chip erase). If the last write is instead 0x30 at any address, it issues cmd_kind 3 (sector erase) with that address. A broken second unlock pair issues nothing.
- R4: Buffered program works as follows. Data 0x25 at a sector address (the address bits from SECT_LSB upward) sets mode 4 (buffer-load). The next write, to the same sector, gives the word count minus one. Each of the count+1 loads then issues cmd_kind 4 with its address and data. Finally 0x29 to the same sector issues cmd_kind 5, with the first load address and the count, and the mode returns to 0 (read-array).
- R5: The decoder enters mode 5 (buffer-abort) and issues no command in any of these cases: a load whose page (the address bits from log2(BUF_WORDS) upward) differs from the page of the first load; a count above BUF_WORDS-1; a count write to another sector; a write other than 0x29 where the confirm is due.
- R6: In mode 5, a single 0xF0 write is ignored. Only the full sequence 0xAA@0xAAA, 0x55@0x555, 0xF0@0xAAA leaves it, issuing cmd_kind 8 (reset) and setting mode 0.
- R7: The decoder comes out of reset in mode 0 with cmd_valid low. A single 0xF0 write at any address in mode 0, 1 or 2 issues cmd_kind 8 and sets mode 0. Unlock then 0x90@0xAAA issues cmd_kind 10 and sets mode 1 (autoselect). In mode 1, every write other than 0xF0 or a query entry is ignored.
- R8: A single write of 0x98 to address 0x0AA, in mode 0 or 1, issues cmd_kind 9 and sets mode 2 (query). The same data at any other address has no effect.
- R9: While busy is high, a 0xB0 write issues cmd_kind 6 (suspend) and marks the decoder suspended. With busy low and the decoder idle in mode 0, a 0x30 write issues cmd_kind 7 (resume) only when suspended, and it clears the mark. Otherwise 0x30 does nothing.
- R10: Unlock then 0x20@0xAAA sets mode 3 (unlock-bypass) without a pulse. In mode 3, 0xA0 at any address followed by one address/data write issues cmd_kind 1. The pair 0x90 then 0x00 returns the decoder to mode 0. Every other write is ignored.
- R11: While busy is high, every write other than 0xB0 is ignored, and a partly entered sequence keeps its position until busy drops.
- R12: Matching compares only data bits 7:0 and address bits DEC_W-1:0. Higher bits still appear on cmd_addr and cmd_data.
- R13: Unlock then 0x88@0xAAA issues cmd_kind 11 (secured-region entry) and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Embedded program or erase in progress |
| cmd_valid | output | 1 | Decoded command pulse |
| cmd_kind | output | 4 | Command code, 0 when no pulse |
| cmd_addr | output | ADDR_W | Address carried with the command |
| cmd_data | output | DATA_W | Data carried with the command |
| mode | output | 3 | Current mode code |

## Verification
The hardest state to reach is buffer-abort, because the sequence must stay exactly right up to a precise breaking point. The stimulus drives complete buffer sequences and then breaks each one at a different place: a load in the neighbouring page, an oversized count, and a surplus load where the confirm is due. Each run then tries the single-write reset, which must fail, before the full three-write reset. Suspend and held-sequence behaviour are reached by raising busy in the middle of an unlock pair and dropping it before the pair is completed.

// File: rtl/nfcd_pkg.sv
// Shared codes for the NOR command decoder.
// Assumes one write per strobe; all codes fit the port widths used by the top.
package nfcd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_CFI     = 3'd2,
        MODE_BYPASS  = 3'd3,
        MODE_BUFLOAD = 3'd4,
        MODE_ABORT   = 3'd5
    } mode_e;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_PROGRAM  = 4'd1,
        CMD_CHIP_ERS = 4'd2,
        CMD_SECT_ERS = 4'd3,
        CMD_BUF_WORD = 4'd4,
        CMD_BUF_PROG = 4'd5,
        CMD_SUSPEND  = 4'd6,
        CMD_RESUME   = 4'd7,
        CMD_RESET    = 4'd8,
        CMD_CFI      = 4'd9,
        CMD_AUTOSEL  = 4'd10,
        CMD_SECURE   = 4'd11
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3,
        ST_BWC, ST_BLOAD, ST_BCONF, ST_BYP_PGM, ST_BYP_EXIT
    } seq_e;

    typedef struct packed {
        logic       at_aaa;
        logic       at_555;
        logic       at_0aa;
        logic [7:0] code;
    } match_t;

endpackage

// File: rtl/nfcd_addr_match.sv
// Compares the command-decode slice of a write against the fixed unlock
// addresses and exposes the low data byte.
// Assumes DEC_W >= 12 so that all three addresses fit.
module nfcd_addr_match #(
    parameter int DEC_W = 12
) (
    input  logic [DEC_W-1:0] addr,
    input  logic [7:0]       data,
    output nfcd_pkg::match_t m
);
    localparam logic [DEC_W-1:0] ADR_AAA = DEC_W'(12'hAAA);
    localparam logic [DEC_W-1:0] ADR_555 = DEC_W'(12'h555);
    localparam logic [DEC_W-1:0] ADR_0AA = DEC_W'(12'h0AA);

    // Flag each fixed address and pass the command byte through.
    always_comb begin
        m.at_aaa = (addr == ADR_AAA);
        m.at_555 = (addr == ADR_555);
        m.at_0aa = (addr == ADR_0AA);
        m.code   = data;
    end
endmodule

// File: rtl/nfcd_buf_track.sv
// Bookkeeping for one buffered program: latched sector, word count,
// page of the first load, remaining loads and first load address.
// Assumes BUF_WORDS is a power of two between 2 and 256.
module nfcd_buf_track #(
    parameter int ADDR_W    = 24,
    parameter int SECT_LSB  = 16,
    parameter int BUF_WORDS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                count_wr,
    input  logic                load,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          code,
    output logic                same_sector,
    output logic                wc_ok,
    output logic                page_ok,
    output logic                last_load,
    output logic [$clog2(BUF_WORDS)-1:0] wc,
    output logic [ADDR_W-1:0]   first_addr
);
    localparam int CNT_W    = $clog2(BUF_WORDS);
    localparam int PAGE_LSB = CNT_W;
    localparam int SECT_W   = ADDR_W - SECT_LSB;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;

    logic [SECT_W-1:0] sect_q;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  wc_q;
    logic              first_q;
    logic [ADDR_W-1:0] addr0_q;

    // Latch sector, count and the first load; count loads down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q  <= '0;
            page_q  <= '0;
            left_q  <= '0;
            wc_q    <= '0;
            first_q <= 1'b0;
            addr0_q <= '0;
        end else begin
            if (start) sect_q <= addr[ADDR_W-1:SECT_LSB];
            if (count_wr) begin
                wc_q    <= code[CNT_W-1:0];
                left_q  <= code[CNT_W-1:0];
                first_q <= 1'b1;
            end else if (load) begin
                first_q <= 1'b0;
                left_q  <= left_q - 1'b1;
                if (first_q) begin
                    page_q  <= addr[ADDR_W-1:PAGE_LSB];
                    addr0_q <= addr;
                end
            end
        end
    end

    // Qualify the current write against the latched context.
    always_comb begin
        same_sector = (addr[ADDR_W-1:SECT_LSB] == sect_q);
        wc_ok       = (code <= 8'(BUF_WORDS - 1));
        page_ok     = first_q || (addr[ADDR_W-1:PAGE_LSB] == page_q);
        last_load   = (left_q == '0);
        wc          = wc_q;
        first_addr  = addr0_q;
    end
endmodule

// File: rtl/nfcd_decoder.sv
// Top of the NOR command decoder: walks unlock/command sequences on each
// strobed write and emits a registered one-cycle command pulse plus mode.
// Assumes wr_stb is already edge-qualified and busy comes from the engine.
module nfcd_decoder #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int DEC_W     = 12,
    parameter int SECT_LSB  = 16,
    parameter int BUF_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              cmd_valid,
    output logic [3:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [2:0]        mode
);
    import nfcd_pkg::*;
    localparam int CNT_W = $clog2(BUF_WORDS);

    match_t             m;
    seq_e               st_q, st_d;
    mode_e              mode_q, mode_d;
    logic               susp_q, susp_d;
    logic               fire;
    cmd_e               kind;
    logic [ADDR_W-1:0]  oaddr;
    logic [DATA_W-1:0]  odata;
    logic               bt_start, bt_count, bt_load;
    logic               same_sector, wc_ok, page_ok, last_load;
    logic [CNT_W-1:0]   bt_wc;
    logic [ADDR_W-1:0]  bt_first;
    logic               vld_q;
    cmd_e               kind_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;

    nfcd_addr_match #(.DEC_W(DEC_W)) u_match (
        .addr (wr_addr[DEC_W-1:0]),
        .data (wr_data[7:0]),
        .m    (m)
    );

    nfcd_buf_track #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BUF_WORDS(BUF_WORDS)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bt_start),
        .count_wr    (bt_count),
        .load        (bt_load),
        .addr        (wr_addr),
        .code        (wr_data[7:0]),
        .same_sector (same_sector),
        .wc_ok       (wc_ok),
        .page_ok     (page_ok),
        .last_load   (last_load),
        .wc          (bt_wc),
        .first_addr  (bt_first)
    );

    // Next sequence step, mode, suspend mark and command for this write.
    always_comb begin
        st_d = st_q; mode_d = mode_q; susp_d = susp_q;
        fire = 1'b0; kind = CMD_NONE; oaddr = wr_addr; odata = wr_data;
        bt_start = 1'b0; bt_count = 1'b0; bt_load = 1'b0;
        if (wr_stb && busy) begin
            if (m.code == 8'hB0 && !susp_q) begin
                fire = 1'b1; kind = CMD_SUSPEND; susp_d = 1'b1;
            end
        end else if (wr_stb) begin
            case (st_q)
                ST_IDLE: case (mode_q)
                    MODE_READ: begin
                        if (m.at_aaa && m.code == 8'hAA) st_d = ST_U1;
                        else if (m.code == 8'hF0) begin fire = 1'b1; kind = CMD_RESET; end
                        else if (m.at_0aa && m.code == 8'h98) begin
                            fire = 1'b1; kind = CMD_CFI; mode_d = MODE_CFI;
                        end else if (m.code == 8'h30 && susp_q) begin
                            fire = 1'b1; kind = CMD_RESUME; susp_d = 1'b0;
                        end
                    end
                    MODE_ABORT: if (m.at_aaa && m.code == 8'hAA) st_d = ST_U1;
                    MODE_AUTOSEL: begin
                        if (m.code == 8'hF0) begin fire = 1'b1; kind = CMD_RESET; mode_d = MODE_READ; end
                        else if (m.at_0aa && m.code == 8'h98) begin
                            fire = 1'b1; kind = CMD_CFI; mode_d = MODE_CFI;
                        end
                    end
                    MODE_CFI: if (m.code == 8'hF0) begin
                        fire = 1'b1; kind = CMD_RESET; mode_d = MODE_READ;
                    end
                    MODE_BYPASS: begin
                        if (m.code == 8'hA0) st_d = ST_BYP_PGM;
                        else if (m.code == 8'h90) st_d = ST_BYP_EXIT;
                    end
                    default: ;
                endcase
                ST_U1: st_d = (m.at_555 && m.code == 8'h55) ? ST_U2 : ST_IDLE;
                ST_U2: begin
                    st_d = ST_IDLE;
                    if (mode_q == MODE_ABORT) begin
                        if (m.at_aaa && m.code == 8'hF0) begin
                            fire = 1'b1; kind = CMD_RESET; mode_d = MODE_READ;
                        end
                    end else if (m.code == 8'h25) begin
                        bt_start = 1'b1; st_d = ST_BWC; mode_d = MODE_BUFLOAD;
                    end else if (m.at_aaa) begin
                        case (m.code)
                            8'hA0: st_d = ST_PGM;
                            8'h80: st_d = ST_E1;
                            8'h90: begin fire = 1'b1; kind = CMD_AUTOSEL; mode_d = MODE_AUTOSEL; end
                            8'h88: begin fire = 1'b1; kind = CMD_SECURE; end
                            8'h20: mode_d = MODE_BYPASS;
                            8'hF0: begin fire = 1'b1; kind = CMD_RESET; end
                            default: ;
                        endcase
                    end
                end
                ST_PGM, ST_BYP_PGM: begin
                    fire = 1'b1; kind = CMD_PROGRAM; st_d = ST_IDLE;
                end
                ST_E1: st_d = (m.at_aaa && m.code == 8'hAA) ? ST_E2 : ST_IDLE;
                ST_E2: st_d = (m.at_555 && m.code == 8'h55) ? ST_E3 : ST_IDLE;
                ST_E3: begin
                    st_d = ST_IDLE;
                    if (m.at_aaa && m.code == 8'h10) begin fire = 1'b1; kind = CMD_CHIP_ERS; end
                    else if (m.code == 8'h30) begin fire = 1'b1; kind = CMD_SECT_ERS; end
                end
                ST_BWC: begin
                    if (same_sector && wc_ok) begin bt_count = 1'b1; st_d = ST_BLOAD; end
                    else begin st_d = ST_IDLE; mode_d = MODE_ABORT; end
                end
                ST_BLOAD: begin
                    if (page_ok) begin
                        bt_load = 1'b1; fire = 1'b1; kind = CMD_BUF_WORD;
                        if (last_load) st_d = ST_BCONF;
                    end else begin st_d = ST_IDLE; mode_d = MODE_ABORT; end
                end
                ST_BCONF: begin
                    st_d = ST_IDLE;
                    if (m.code == 8'h29 && same_sector) begin
                        fire = 1'b1; kind = CMD_BUF_PROG; mode_d = MODE_READ;
                        oaddr = bt_first; odata = DATA_W'(bt_wc);
                    end else mode_d = MODE_ABORT;
                end
                ST_BYP_EXIT: begin
                    st_d = ST_IDLE;
                    if (m.code == 8'h00) mode_d = MODE_READ;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Sequence, mode and suspend registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_READ;
            susp_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
            susp_q <= susp_d;
        end
    end

    // Registered command pulse with its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            kind_q <= CMD_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            vld_q  <= fire;
            kind_q <= fire ? kind : CMD_NONE;
            if (fire) begin
                addr_q <= oaddr;
                data_q <= odata;
            end
        end
    end

    assign cmd_valid = vld_q;
    assign cmd_kind  = kind_q;
    assign cmd_addr  = addr_q;
    assign cmd_data  = data_q;
    assign mode      = mode_q;
endmodule

// File: rtl/nfcd_checker.sv
// Port-level properties of the NOR command decoder, bound to every instance.
// Assumes the mode and command codes of nfcd_pkg.
module nfcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       busy,
    input logic       cmd_valid,
    input logic [3:0] cmd_kind,
    input logic [2:0] mode
);
    logic seen_q;
    logic susp_q;

    // Track one clean cycle since reset and the suspend/resume pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (cmd_valid && cmd_kind == 4'd6) susp_q <= 1'b1;
            else if (cmd_valid && cmd_kind == 4'd7) susp_q <= 1'b0;
        end
    end

    assert_pulse_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && cmd_valid |-> $past(wr_stb));

    assert_busy_only_suspend_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && cmd_valid && $past(busy) |-> cmd_kind == 4'd6);

    assert_abort_exit_by_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(mode) == 3'd5 && mode != 3'd5 |-> cmd_valid && cmd_kind == 4'd8);

    assert_autosel_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(mode) == 3'd1 && mode != 3'd1 |-> cmd_valid && (cmd_kind == 4'd8 || cmd_kind == 4'd9));

    assert_resume_needs_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 4'd7 |-> susp_q);

    assert_mode_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> mode <= 3'd5);
endmodule

bind nfcd_decoder nfcd_checker u_nfcd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .mode      (mode)
);

// File: tb/tb_nfcd_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected pulses, the monitor pops them.
module tb_nfcd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        busy = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid;
    logic [3:0]  cmd_kind;
    logic [23:0] cmd_addr;
    logic [15:0] cmd_data;
    logic [2:0]  mode;

    int    n_chk = 0;
    int    n_err = 0;
    int    pushed = 0;
    string cur_tag = "R7";
    logic [3:0]  kq[$];
    logic [23:0] aq[$];
    logic [15:0] dq[$];
    string       tq[$];

    always #2.5 clk = ~clk;

    nfcd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mode(mode)
    );

    task automatic expect_cmd(input logic [3:0] k, input logic [23:0] a,
                              input logic [15:0] d, input string t);
        kq.push_back(k); aq.push_back(a); dq.push_back(d); tq.push_back(t);
        pushed++;
    endtask

    // One write; if a pulse was queued for it, it must have appeared by now.
    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
        if (pushed > 0) begin
            n_chk++;
            if (kq.size() != 0) begin
                n_err++;
                $display("FAIL %s: pulse missing one cycle after write, pending=%0d expected 0",
                         tq[0], kq.size());
            end
            pushed = 0;
        end
    endtask

    task automatic unlock();
        wr(24'h000AAA, 16'h00AA);
        wr(24'h000555, 16'h0055);
    endtask

    task automatic check_mode(input logic [2:0] exp_m, input string t);
        n_chk++;
        if (mode !== exp_m) begin
            n_err++;
            $display("FAIL %s: mode=%0d expected %0d", t, mode, exp_m);
        end
    endtask

    // Monitor: every pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_chk++;
            if (kq.size() == 0) begin
                n_err++;
                $display("FAIL %s: unexpected kind=%0d addr=%h data=%h expected no command",
                         cur_tag, cmd_kind, cmd_addr, cmd_data);
            end else begin
                if (cmd_kind !== kq[0] || cmd_addr !== aq[0] || cmd_data !== dq[0]) begin
                    n_err++;
                    $display("FAIL %s: kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                             tq[0], cmd_kind, cmd_addr, cmd_data, kq[0], aq[0], dq[0]);
                end
                void'(kq.pop_front()); void'(aq.pop_front());
                void'(dq.pop_front()); void'(tq.pop_front());
            end
        end
    end

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check_mode(3'd0, "R7");
        n_chk++;
        if (cmd_valid !== 1'b0) begin
            n_err++; $display("FAIL R7: cmd_valid=%b expected 0", cmd_valid);
        end

        // R2 single program
        cur_tag = "R2";
        unlock(); wr(24'h000AAA, 16'h00A0);
        expect_cmd(4'd1, 24'h123456, 16'h005A, "R2");
        wr(24'h123456, 16'h005A);
        check_mode(3'd0, "R2");

        // R12 high address and data bits ignored in matching
        cur_tag = "R12";
        wr(24'hFF0AAA, 16'hFFAA); wr(24'h7F0555, 16'h3355); wr(24'h120AAA, 16'h12A0);
        expect_cmd(4'd1, 24'h0000F0, 16'hBEEF, "R12");
        wr(24'h0000F0, 16'hBEEF);
        expect_cmd(4'd9, 24'hFF00AA, 16'h7798, "R12");
        wr(24'hFF00AA, 16'h7798);
        expect_cmd(4'd8, 24'h000000, 16'h00F0, "R12");
        wr(24'h000000, 16'h00F0);

        // R1 mismatching unlock writes leave nothing armed
        cur_tag = "R1";
        wr(24'h000AAA, 16'h00AA); wr(24'h000554, 16'h0055);
        wr(24'h000AAA, 16'h00A0); wr(24'h000100, 16'h0077);
        wr(24'h000AAB, 16'h00AA); wr(24'h000555, 16'h0055);
        wr(24'h000AAA, 16'h00A0); wr(24'h000100, 16'h0077);
        check_mode(3'd0, "R1");

        // R3 chip erase, sector erase, broken second unlock
        cur_tag = "R3";
        unlock(); wr(24'h000AAA, 16'h0080); unlock();
        expect_cmd(4'd2, 24'h000AAA, 16'h0010, "R3");
        wr(24'h000AAA, 16'h0010);
        unlock(); wr(24'h000AAA, 16'h0080); unlock();
        expect_cmd(4'd3, 24'h050000, 16'h0030, "R3");
        wr(24'h050000, 16'h0030);
        unlock(); wr(24'h000AAA, 16'h0080);
        wr(24'h000AAA, 16'h00AA); wr(24'h000556, 16'h0055); wr(24'h000AAA, 16'h0010);

        // R4 buffered program of four words
        cur_tag = "R4";
        unlock(); wr(24'h030000, 16'h0025);
        check_mode(3'd4, "R4");
        wr(24'h030000, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            expect_cmd(4'd4, 24'h030040 + 24'(i), 16'h1000 + 16'(i), "R4");
            wr(24'h030040 + 24'(i), 16'h1000 + 16'(i));
        end
        expect_cmd(4'd5, 24'h030040, 16'h0003, "R4");
        wr(24'h030000, 16'h0029);
        check_mode(3'd0, "R4");

        // R5 load outside the first page, then R6 exits
        cur_tag = "R5";
        unlock(); wr(24'h030000, 16'h0025); wr(24'h030000, 16'h0002);
        expect_cmd(4'd4, 24'h030040, 16'h0001, "R5");
        wr(24'h030040, 16'h0001);
        wr(24'h030060, 16'h0002);
        check_mode(3'd5, "R5");
        cur_tag = "R6";
        wr(24'h000000, 16'h00F0);
        check_mode(3'd5, "R6");
        unlock(); wr(24'h000AAA, 16'h00A0);
        check_mode(3'd5, "R6");
        unlock();
        expect_cmd(4'd8, 24'h000AAA, 16'h00F0, "R6");
        wr(24'h000AAA, 16'h00F0);
        check_mode(3'd0, "R6");

        // R5 oversized count
        cur_tag = "R5";
        unlock(); wr(24'h030000, 16'h0025); wr(24'h030000, 16'h0040);
        check_mode(3'd5, "R5");
        unlock();
        expect_cmd(4'd8, 24'h000AAA, 16'h00F0, "R5");
        wr(24'h000AAA, 16'h00F0);

        // R5 count written to another sector
        unlock(); wr(24'h030000, 16'h0025); wr(24'h040000, 16'h0001);
        check_mode(3'd5, "R5");
        unlock();
        expect_cmd(4'd8, 24'h000AAA, 16'h00F0, "R5");
        wr(24'h000AAA, 16'h00F0);

        // R5 surplus load where confirm is due
        unlock(); wr(24'h030000, 16'h0025); wr(24'h030000, 16'h0000);
        expect_cmd(4'd4, 24'h030080, 16'h0011, "R5");
        wr(24'h030080, 16'h0011);
        wr(24'h030081, 16'h0011);
        check_mode(3'd5, "R5");
        unlock();
        expect_cmd(4'd8, 24'h000AAA, 16'h00F0, "R5");
        wr(24'h000AAA, 16'h00F0);
        check_mode(3'd0, "R5");

        // R7 autoselect entry, commands ignored inside, F0 exit
        cur_tag = "R7";
        unlock();
        expect_cmd(4'd10, 24'h000AAA, 16'h0090, "R7");
        wr(24'h000AAA, 16'h0090);
        check_mode(3'd1, "R7");
        unlock(); wr(24'h000AAA, 16'h00A0); wr(24'h000200, 16'h0033);
        check_mode(3'd1, "R7");
        expect_cmd(4'd8, 24'h000123, 16'h00F0, "R7");
        wr(24'h000123, 16'h00F0);
        check_mode(3'd0, "R7");

        // R8 query entry only at the query address
        cur_tag = "R8";
        wr(24'h0000AB, 16'h0098);
        check_mode(3'd0, "R8");
        expect_cmd(4'd9, 24'h0000AA, 16'h0098, "R8");
        wr(24'h0000AA, 16'h0098);
        check_mode(3'd2, "R8");
        expect_cmd(4'd8, 24'h000000, 16'h00F0, "R8");
        wr(24'h000000, 16'h00F0);

        // R13 secured-region entry
        cur_tag = "R13";
        unlock();
        expect_cmd(4'd11, 24'h000AAA, 16'h0088, "R13");
        wr(24'h000AAA, 16'h0088);
        check_mode(3'd0, "R13");

        // R10 unlock bypass
        cur_tag = "R10";
        unlock(); wr(24'h000AAA, 16'h0020);
        check_mode(3'd3, "R10");
        wr(24'h000000, 16'h00F0);
        check_mode(3'd3, "R10");
        wr(24'h000000, 16'h00A0);
        expect_cmd(4'd1, 24'h001000, 16'h0042, "R10");
        wr(24'h001000, 16'h0042);
        wr(24'h000000, 16'h0090); wr(24'h000000, 16'h0055);
        check_mode(3'd3, "R10");
        wr(24'h000000, 16'h0090); wr(24'h000000, 16'h0000);
        check_mode(3'd0, "R10");

        // R11 writes ignored while busy; R9 suspend and resume
        cur_tag = "R11";
        busy = 1'b1;
        unlock(); wr(24'h000AAA, 16'h00A0); wr(24'h000300, 16'h0044);
        cur_tag = "R9";
        wr(24'h000000, 16'h0030);
        expect_cmd(4'd6, 24'h000000, 16'h00B0, "R9");
        wr(24'h000000, 16'h00B0);
        busy = 1'b0;
        expect_cmd(4'd7, 24'h000000, 16'h0030, "R9");
        wr(24'h000000, 16'h0030);
        wr(24'h000000, 16'h0030);
        cur_tag = "R11";
        wr(24'h000AAA, 16'h00AA);
        busy = 1'b1;
        wr(24'h000555, 16'h0055); wr(24'h000AAA, 16'h0080);
        busy = 1'b0;
        wr(24'h000555, 16'h0055); wr(24'h000AAA, 16'h00A0);
        expect_cmd(4'd1, 24'h000400, 16'h0066, "R11");
        wr(24'h000400, 16'h0066);
        check_mode(3'd0, "R11");

        repeat (3) @(negedge clk);
        n_chk++;
        if (kq.size() != 0) begin
            n_err++;
            $display("FAIL %s: %0d expected commands never seen, expected 0", tq[0], kq.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule